// File: doc/BRIEF.md
# Video RAM Indirect Access Port

This block gives a host processor indirect access to a 16-bit-wide video RAM through three word registers. A pointer register holds the RAM address. A data window register reads or writes the RAM word at that address. A signed step register holds the modulo that is added to the pointer after every write through the data window. The RAM side is a plain synchronous single-port interface with a read latency of one clock. The block drives enable, write enable, address and write data. It takes read data back in the cycle after the enable.

The host side uses a strobe-and-acknowledge protocol. The host raises `hst_req` for one clock with the access type, a 3-bit byte offset and the write data. It must not raise `hst_req` again until `hst_ack` has pulsed. A controller with three states handles each access:

- `ST_IDLE` accepts a request. Register accesses, RAM writes and ignored accesses go from here to `ST_ACK`. Reads of the RAM go to `ST_RDWAIT`.
- `ST_RDWAIT` spends the RAM latency cycle and captures the word that comes back, then goes to `ST_ACK`.
- `ST_ACK` raises the acknowledge for one clock and returns to `ST_IDLE`.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer and the step are 0, `hst_ack` is low and `ram_en` is low.
- R2: A write to offset 0 loads the pointer with the low AW bits of the write word. It makes no RAM access.
- R3: A write to offset 2 writes the word into RAM at the pointer. The pointer then becomes pointer plus step, modulo 2^AW.
- R4: A read of offset 0 or offset 2 returns the RAM word at the pointer, and the pointer does not move.
- R5: A write to offset 4 loads the 16-bit step register. A read of offset 4 returns that register.
- R6: The step is two's complement, so a negative step moves the pointer down and wraps below address 0.
- R7: A byte write (`hst_byte`=1) to an even offset takes the byte from `hst_wdata[7:0]` and uses it in both halves of the word. This holds for all three registers.
- R8: A byte access to an odd offset is acknowledged with `hst_rdata`=0. It makes no RAM access and leaves the pointer and the step unchanged.
- R9: A write, a step read or an ignored access is acknowledged one clock after the request. A RAM read is acknowledged two clocks after the request, once the RAM latency has passed. Read data is valid while `hst_ack` is high.
- R10: `hst_ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | One-cycle access strobe |
| hst_wr | input | 1 | 1 for write, 0 for read |
| hst_byte | input | 1 | 1 for byte access, 0 for word access |
| hst_addr | input | 3 | Byte offset: 0 pointer, 2 data window, 4 step |
| hst_wdata | input | 16 | Write data (byte in bits 7:0) |
| hst_rdata | output | 16 | Read data, valid with `hst_ack` |
| hst_ack | output | 1 | Access complete pulse |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one clock after `ram_en` |

## Verification
Runs of data-window writes are swept over several step values. The steps include +1, -1, 0, odd positive and negative strides, and values that span half of the address space. Each run starts from pointers spread across the array. Together these separate correct stepping from missing sign extension, from a missing wrap, and from a pointer that moves on reads.

Each written word is read back through both offset 0 and offset 2, twice. This separates the read path from the write path and shows whether a read moves the pointer.

Byte writes with a varying low byte and junk in the high byte show whether the byte is duplicated and whether the correct lane is taken. Odd-offset byte accesses, each followed by a read of both registers, show whether anything changed. The acknowledge latency is measured on every access.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDWAIT = 2'd1,
        ST_ACK    = 2'd2
    } vp_state_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SETPTR = 3'd1,
        OP_WRDATA = 3'd2,
        OP_SETSTP = 3'd3,
        OP_RDRAM  = 3'd4,
        OP_RDSTP  = 3'd5
    } vp_op_t;

    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STEP = 2'd2;

endpackage

// File: rtl/vram_port_decode.sv
module vram_port_decode
    import vram_port_pkg::*;
(
    input  logic       wr,
    input  logic       byte_acc,
    input  logic [2:0] offs,
    output vp_op_t     op
);
    logic [1:0] sel;
    assign sel = offs[2:1];

    always_comb begin
        op = OP_NONE;
        if (!offs[0]) begin
            if (wr) begin
                unique case (sel)
                    SEL_PTR:  op = OP_SETPTR;
                    SEL_DATA: op = OP_WRDATA;
                    SEL_STEP: op = OP_SETSTP;
                    default:  op = OP_NONE;
                endcase
            end else begin
                unique case (sel)
                    SEL_PTR, SEL_DATA: op = OP_RDRAM;
                    SEL_STEP:          op = OP_RDSTP;
                    default:           op = OP_NONE;
                endcase
            end
        end
    end

    always_comb begin
        if (byte_acc && offs[0]) begin
            AST_ODD_BYTE_DEAD: assert (op == OP_NONE); // R8
        end
    end
endmodule

// File: rtl/vram_port_regs.sv
module vram_port_regs #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ptr,
    input  logic          ld_step,
    input  logic          advance,
    input  logic [DW-1:0] wword,
    output logic [AW-1:0] ptr,
    output logic [DW-1:0] step
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            step <= '0;
        end else begin
            if (ld_ptr)       ptr <= wword[AW-1:0];
            else if (advance) ptr <= ptr + step[AW-1:0];
            if (ld_step)      step <= wword;
        end
    end

    AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_ptr, ld_step, advance}) <= 1); // R3
endmodule

// File: rtl/vram_port.sv
module vram_port
    import vram_port_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_req,
    input  logic          hst_wr,
    input  logic          hst_byte,
    input  logic [2:0]    hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    output logic          hst_ack,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);
    localparam int HW = DW / 2;

    vp_state_t     state, nstate;
    vp_op_t        op;
    logic          take;
    logic [DW-1:0] wword;
    logic [AW-1:0] ptr;
    logic [DW-1:0] step;
    logic [DW-1:0] rdq;

    assign take  = (state == ST_IDLE) && hst_req;
    assign wword = hst_byte ? {hst_wdata[HW-1:0], hst_wdata[HW-1:0]} : hst_wdata;

    vram_port_decode u_dec (
        .wr       (hst_wr),
        .byte_acc (hst_byte),
        .offs     (hst_addr),
        .op       (op)
    );

    vram_port_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_ptr  (take && op == OP_SETPTR),
        .ld_step (take && op == OP_SETSTP),
        .advance (take && op == OP_WRDATA),
        .wword   (wword),
        .ptr     (ptr),
        .step    (step)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (hst_req) nstate = (op == OP_RDRAM) ? ST_RDWAIT : ST_ACK;
            ST_RDWAIT: nstate = ST_ACK;
            ST_ACK:    nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdq <= '0;
        end else if (state == ST_RDWAIT) begin
            rdq <= ram_rdata;
        end else if (take) begin
            rdq <= (op == OP_RDSTP) ? step : '0;
        end
    end

    always_comb begin
        hst_ack   = (state == ST_ACK);
        hst_rdata = rdq;
        ram_en    = take && (op == OP_WRDATA || op == OP_RDRAM);
        ram_we    = take && (op == OP_WRDATA);
        ram_addr  = ptr;
        ram_wdata = wword;
    end

    AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> !hst_ack ##1 hst_ack); // R9
    AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> $stable(ptr)); // R4
    AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ram_addr == $past(ram_addr) + $past(step[AW-1:0])); // R3
    AST_BYTE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && hst_byte) |-> ram_wdata[DW-1:HW] == ram_wdata[HW-1:0]); // R7
    AST_ODD_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && hst_byte && hst_addr[0]) |-> !ram_en); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack); // R10
    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en); // R3
endmodule

// File: tb/vram_port_test.sv
module vram_port_test;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_req = 1'b0, hst_wr = 1'b0, hst_byte = 1'b0;
    logic [2:0]    hst_addr = '0;
    logic [15:0]   hst_wdata = '0;
    logic [15:0]   hst_rdata;
    logic          hst_ack, ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [15:0]   ram_wdata, ram_rdata;

    logic [15:0] mem [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    logic [AW-1:0] exp_ptr;
    logic [15:0] exp_step;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    vram_port #(.AW(AW), .DW(16)) uut (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
        .hst_byte(hst_byte), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_ack(hst_ack), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic bt, input logic [2:0] a,
                       input logic [15:0] d, output logic [15:0] q, output int lat);
        @(negedge clk);
        hst_req = 1'b1; hst_wr = wr; hst_byte = bt; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0;
        lat = 1;
        while (!hst_ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        q = hst_rdata;
    endtask

    task automatic set_ptr(input logic [15:0] v);
        logic [15:0] q; int lat;
        acc(1'b1, 1'b0, 3'd0, v, q, lat);
        check("R9 ptr write latency", 16'(lat), 16'd1);
        exp_ptr = v[AW-1:0];
    endtask

    task automatic set_step(input logic [15:0] v);
        logic [15:0] q; int lat;
        acc(1'b1, 1'b0, 3'd4, v, q, lat);
        check("R9 step write latency", 16'(lat), 16'd1);
        exp_step = v;
    endtask

    task automatic wr_data(input logic [15:0] v);
        logic [15:0] q; int lat;
        acc(1'b1, 1'b0, 3'd2, v, q, lat);
        check("R9 data write latency", 16'(lat), 16'd1);
        exp_mem[exp_ptr] = v;
        exp_ptr = exp_ptr + exp_step[AW-1:0];
    endtask

    task automatic rd_both(input string tag);
        logic [15:0] q; int lat;
        for (int k = 0; k < 2; k++) begin
            acc(1'b0, 1'b0, 3'd2, 16'h0, q, lat);
            check({tag, " R4 window read"}, q, exp_mem[exp_ptr]);
            check("R9 RAM read latency", 16'(lat), 16'd2);
            acc(1'b0, 1'b0, 3'd0, 16'h0, q, lat);
            check({tag, " R4 pointer-offset read"}, q, exp_mem[exp_ptr]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int lat;
        logic [15:0] steps [8];
        steps = '{16'h0001, 16'hFFFF, 16'h0000, 16'h0003, 16'hFFFB,
                  16'h0080, 16'hFF81, 16'h0025};
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 16'(i * 257) ^ 16'h5A5A;
            exp_mem[i] = mem[i];
        end
        exp_ptr = '0; exp_step = '0;
        repeat (3) @(negedge clk);
        check("R1 ack low in reset", {15'b0, hst_ack}, 16'd0);
        check("R1 ram_en low in reset", {15'b0, ram_en}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        acc(1'b0, 1'b0, 3'd4, 16'h0, q, lat);
        check("R1 step reset", q, 16'h0000);
        check("R9 step read latency", 16'(lat), 16'd1);
        rd_both("R1 pointer reset");

        // R2 / R3 / R5 / R6 sweep of steps and starting points
        for (int s = 0; s < 8; s++) begin
            set_step(steps[s]);
            acc(1'b0, 1'b0, 3'd4, 16'h0, q, lat);
            check("R5 step readback", q, steps[s]);
            for (int st = 3; st < DEPTH; st += 61) begin
                logic [AW-1:0] first;
                set_ptr(16'(st) | 16'hAB00);
                first = exp_ptr;
                for (int w = 0; w < 4; w++) wr_data(16'(s * 4096 + st * 16 + w) ^ 16'hC3C3);
                set_ptr({8'h00, first});
                for (int w = 0; w < 4; w++) begin
                    rd_both("R3 R6 stepped write");
                    set_ptr({8'h00, exp_ptr + steps[s][AW-1:0]});
                end
            end
        end

        // R7 byte writes on even offsets
        set_step(16'h0001);
        for (int b = 0; b < 256; b += 17) begin
            acc(1'b1, 1'b1, 3'd0, {8'hEE, 8'(b)}, q, lat);
            exp_ptr = 8'(b);
            rd_both("R7 byte pointer write");
            acc(1'b1, 1'b1, 3'd2, {8'h99, 8'(b ^ 8'h3C)}, q, lat);
            exp_mem[exp_ptr] = {8'(b ^ 8'h3C), 8'(b ^ 8'h3C)};
            exp_ptr = exp_ptr + 1'b1;
            set_ptr(16'(b));
            rd_both("R7 byte data dup");
        end
        acc(1'b1, 1'b1, 3'd4, 16'h77FE, q, lat);
        acc(1'b0, 1'b0, 3'd4, 16'h0, q, lat);
        check("R7 byte step dup", q, 16'hFEFE);
        exp_step = 16'hFEFE;

        // R8 odd byte accesses do nothing
        set_ptr(16'h0040);
        for (int a = 1; a < 8; a += 2) begin
            acc(1'b1, 1'b1, 3'(a), 16'h1234, q, lat);
            check("R9 R8 odd write latency", 16'(lat), 16'd1);
            acc(1'b0, 1'b1, 3'(a), 16'h0, q, lat);
            check("R8 odd read data", q, 16'h0000);
            acc(1'b0, 1'b0, 3'd4, 16'h0, q, lat);
            check("R8 step untouched", q, 16'hFEFE);
            rd_both("R8 pointer and RAM untouched");
        end
        wr_data(16'hBEEF);
        set_ptr(16'h0040);
        rd_both("R8 R6 write after odd accesses");
        set_ptr(16'h003E);
        rd_both("R6 negative step wrap target");

        // R10 ack pulse width
        @(negedge clk);
        hst_req = 1'b1; hst_wr = 1'b0; hst_byte = 1'b0; hst_addr = 3'd2;
        @(negedge clk); hst_req = 1'b0;
        @(negedge clk);
        check("R10 ack high", {15'b0, hst_ack}, 16'd1);
        @(negedge clk);
        check("R10 ack drops", {15'b0, hst_ack}, 16'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule